// File: doc/BRIEF.md
# Table-Driven Math Execute Stage

This block is the execute stage of a single-cycle byte processor with no accumulator. Each instruction carries four bytes: an opcode and three operands. The first two operands form a 16-bit address into a byte-wide general register memory. Arithmetic does not use an ALU. Instead, a preloaded lookup table is indexed by a function selector and two byte operands, and it returns a 16-bit result. That result goes into a math register pair. Separate move instructions copy either byte of the pair back into any register location. A compare instruction checks a register against an immediate and keeps a one-hot less/equal/greater flag set for a branch unit.

The block has two phases, chosen by the `run` pin. While `run` is low, the table load stream is open. Each beat with `ld_valid` high is written in the cycle it is presented, `ld_ready` is high, and instructions are refused. While `run` is high, the instruction stream is open instead and the load stream is refused. A stream only accepts a beat when both its valid and its ready are high. The producer must hold a beat until it sees ready. No beat is ever buffered. Every accepted instruction finishes on the clock edge that accepts it.

The logical table address is 20 bits, laid out as {selector[3:0], first operand[7:0], second operand[7:0]}. The stored table is smaller than that. It keeps the low `TBL_OPK` bits of each operand and the low `TBL_FSK` bits of the selector, so both loads and lookups fold onto the same physical entry. The register memory likewise keeps the low `REG_AW` bits of its 16-bit address.

Top module: `lut_math_exec`

## Requirements
- R1: After reset the math pair reads 0x0000, all three compare flags are 0, every register location reads 0, `ins_ready` equals `run` and `ld_ready` equals the inverse of `run`.
- R2: A register address is OP1*256+OP2, and only its low `REG_AW` bits (default 10) select the location. For example, 126,64 and 2,64 both name location 576.
- R3: A load beat accepted while `run` is low writes `ld_data` to the entry whose 20-bit address is {sel,a,b} in bits 19:16, 15:8 and 7:0. That entry is folded as {sel[TBL_FSK-1:0], a[TBL_OPK-1:0], b[TBL_OPK-1:0]} (defaults 2 and 4), and every lookup folds the same way.
- R4: Opcode 0x1s (s = selector) sets the math pair to table[s, reg(OP1,OP2), OP3] at the edge that accepts it. The high byte appears on `math_hi` and the low byte on `math_lo`.
- R5: Opcode 0x20 loads the working register from reg(OP1,OP2) and leaves the math pair unchanged. Opcode 0x3s then sets the math pair to table[s, working register, reg(OP1,OP2)], with the working register as the first operand.
- R6: Opcode 0x40 compares reg(OP1,OP2) with OP3 as unsigned values. It sets exactly one flag: `cmp_lt` (register < OP3), `cmp_eq` or `cmp_gt`. The flags hold until the next compare, and a compare leaves the math pair unchanged.
- R7: Opcode 0x50 writes the math low byte to reg(OP1,OP2), and opcode 0x60 writes the math high byte there. Neither changes the math pair.
- R8: Any other opcode is accepted but changes no state: not the math pair, the flags, the working register or the register memory. This includes a nonzero low nibble on 0x2_, 0x4_, 0x5_ or 0x6_.
- R9: An instruction presented while `run` is low, or with `ins_valid` low, changes no state.
- R10: A load beat presented while `run` is high is refused (`ld_ready` low) and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High: execute phase; low: table load phase |
| ins_valid | input | 1 | Instruction beat valid |
| ins_ready | output | 1 | Instruction accepted when high with valid |
| ins_opc | input | 8 | Opcode byte |
| ins_hi | input | 8 | OP1, register address high byte |
| ins_lo | input | 8 | OP2, register address low byte |
| ins_imm | input | 8 | OP3, immediate operand |
| ld_valid | input | 1 | Table load beat valid |
| ld_ready | output | 1 | Table load accepted when high with valid |
| ld_addr | input | 20 | Table address {sel, a, b} |
| ld_data | input | 16 | Table entry value |
| math_lo | output | 8 | Math pair low byte |
| math_hi | output | 8 | Math pair high byte |
| cmp_lt | output | 1 | Last compare: register below immediate |
| cmp_eq | output | 1 | Last compare: equal |
| cmp_gt | output | 1 | Last compare: register above immediate |

## Verification
Two internal states are not visible directly: the register memory and the working register. A corrupt register byte only shows up when it is used. It appears at the first compare that reads it, one edge later, or at the next table lookup that uses it as an operand. A stale or wrongly loaded working register shows at the math pair on the edge after the following 0x3s instruction. A wrong table fold shows as two operand values that should alias returning different results, or values that should differ returning the same one. A wrongly decoded opcode shows on the flags or the math pair on the very next cycle.

// File: rtl/lme_pkg.sv
package lme_pkg;
  localparam int OPND_W = 8;
  localparam int SEL_W  = 4;
  localparam int RES_W  = 2 * OPND_W;
  localparam int RADR_W = 2 * OPND_W;
  localparam int TADR_W = SEL_W + 2 * OPND_W;

  localparam logic [3:0] CL_RIMM = 4'h1;
  localparam logic [3:0] CL_LDWR = 4'h2;
  localparam logic [3:0] CL_RWR  = 4'h3;
  localparam logic [3:0] CL_CMP  = 4'h4;
  localparam logic [3:0] CL_STLO = 4'h5;
  localparam logic [3:0] CL_STHI = 4'h6;

  typedef struct packed {
    logic             known;
    logic             math_we;
    logic             use_wr;
    logic             wr_we;
    logic             cmp_we;
    logic             reg_we;
    logic             reg_hi;
    logic [SEL_W-1:0] fsel;
  } dec_t;
endpackage

// File: rtl/lme_decode.sv
module lme_decode
  import lme_pkg::*;
(
  input  logic [7:0] opc,
  output dec_t       dec
);
  logic [3:0] cls;
  logic [3:0] sub;
  assign cls = opc[7:4];
  assign sub = opc[3:0];

  always_comb begin
    dec      = '0;
    dec.fsel = sub;
    unique case (cls)
      CL_RIMM: begin
        dec.known   = 1'b1;
        dec.math_we = 1'b1;
      end
      CL_RWR: begin
        dec.known   = 1'b1;
        dec.math_we = 1'b1;
        dec.use_wr  = 1'b1;
      end
      CL_LDWR: begin
        dec.known = (sub == 4'h0);
        dec.wr_we = (sub == 4'h0);
      end
      CL_CMP: begin
        dec.known  = (sub == 4'h0);
        dec.cmp_we = (sub == 4'h0);
      end
      CL_STLO: begin
        dec.known  = (sub == 4'h0);
        dec.reg_we = (sub == 4'h0);
      end
      CL_STHI: begin
        dec.known  = (sub == 4'h0);
        dec.reg_we = (sub == 4'h0);
        dec.reg_hi = 1'b1;
      end
      default: dec.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/lme_regfile.sv
module lme_regfile
  import lme_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RADR_W-1:0] addr,
  output logic [OPND_W-1:0] rdata,
  input  logic              we,
  input  logic [OPND_W-1:0] wdata
);
  localparam int DEPTH = 1 << AW;

  logic [OPND_W-1:0] mem [DEPTH];
  logic [AW-1:0]     idx;
  logic              unused_rf;

  assign idx       = addr[AW-1:0];
  assign unused_rf = ^(addr >> AW);
  assign rdata     = mem[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  // R7: a store is visible at the written location on the next cycle
  assert_store_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(idx)] == $past(wdata)));
endmodule

// File: rtl/lme_table.sv
module lme_table
  import lme_pkg::*;
#(
  parameter int OPK = 4,
  parameter int FSK = 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [TADR_W-1:0] waddr,
  input  logic [RES_W-1:0]  wdata,
  input  logic [SEL_W-1:0]  fsel,
  input  logic [OPND_W-1:0] opa,
  input  logic [OPND_W-1:0] opb,
  output logic [RES_W-1:0]  rdata
);
  localparam int IW    = FSK + 2 * OPK;
  localparam int DEPTH = 1 << IW;

  logic [RES_W-1:0]  mem [DEPTH];
  logic [IW-1:0]     widx;
  logic [IW-1:0]     ridx;
  logic [SEL_W-1:0]  w_sel;
  logic [OPND_W-1:0] w_a;
  logic [OPND_W-1:0] w_b;
  logic              unused_tb;

  assign w_sel = waddr[TADR_W-1 -: SEL_W];
  assign w_a   = waddr[2*OPND_W-1 -: OPND_W];
  assign w_b   = waddr[OPND_W-1:0];

  assign widx = {w_sel[FSK-1:0], w_a[OPK-1:0], w_b[OPK-1:0]};
  assign ridx = {fsel[FSK-1:0],  opa[OPK-1:0], opb[OPK-1:0]};

  assign unused_tb = ^{w_sel >> FSK, w_a >> OPK, w_b >> OPK,
                       fsel >> FSK, opa >> OPK, opb >> OPK};

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/lme_cmp.sv
module lme_cmp
  import lme_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [OPND_W-1:0] lhs,
  input  logic [OPND_W-1:0] rhs,
  output logic [2:0]        flags
);
  logic [2:0] nxt;

  always_comb begin
    if (lhs < rhs)       nxt = 3'b001;
    else if (lhs == rhs) nxt = 3'b010;
    else                 nxt = 3'b100;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  flags <= '0;
    else if (en) flags <= nxt;
  end

  // R6: never more than one relation flag
  assert_flags_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags));
  // R6: a compare always leaves exactly one flag set
  assert_cmp_decides_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($countones(flags) == 1));
endmodule

// File: rtl/lut_math_exec.sv
module lut_math_exec
  import lme_pkg::*;
#(
  parameter int REG_AW  = 10,
  parameter int TBL_OPK = 4,
  parameter int TBL_FSK = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        ins_valid,
  output logic        ins_ready,
  input  logic [7:0]  ins_opc,
  input  logic [7:0]  ins_hi,
  input  logic [7:0]  ins_lo,
  input  logic [7:0]  ins_imm,
  input  logic        ld_valid,
  output logic        ld_ready,
  input  logic [19:0] ld_addr,
  input  logic [15:0] ld_data,
  output logic [7:0]  math_lo,
  output logic [7:0]  math_hi,
  output logic        cmp_lt,
  output logic        cmp_eq,
  output logic        cmp_gt
);
  dec_t              dec;
  logic              fire;
  logic [RADR_W-1:0] raddr;
  logic [OPND_W-1:0] rdata;
  logic [OPND_W-1:0] wr_q;
  logic [RES_W-1:0]  math_q;
  logic [RES_W-1:0]  lut_out;
  logic [OPND_W-1:0] opa;
  logic [OPND_W-1:0] opb;
  logic [OPND_W-1:0] st_data;
  logic [2:0]        flags;

  assign ins_ready = run;
  assign ld_ready  = ~run;
  assign fire      = ins_valid & run;
  assign raddr     = {ins_hi, ins_lo};

  lme_decode u_dec (.opc(ins_opc), .dec(dec));

  assign st_data = dec.reg_hi ? math_q[RES_W-1:OPND_W] : math_q[OPND_W-1:0];

  lme_regfile #(.AW(REG_AW)) u_rf (
    .clk(clk), .rst_n(rst_n), .addr(raddr), .rdata(rdata),
    .we(fire & dec.reg_we), .wdata(st_data)
  );

  assign opa = dec.use_wr ? wr_q  : rdata;
  assign opb = dec.use_wr ? rdata : ins_imm;

  lme_table #(.OPK(TBL_OPK), .FSK(TBL_FSK)) u_tbl (
    .clk(clk), .we(ld_valid & ~run), .waddr(ld_addr), .wdata(ld_data),
    .fsel(dec.fsel), .opa(opa), .opb(opb), .rdata(lut_out)
  );

  lme_cmp u_cmp (
    .clk(clk), .rst_n(rst_n), .en(fire & dec.cmp_we),
    .lhs(rdata), .rhs(ins_imm), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      math_q <= '0;
      wr_q   <= '0;
    end else if (fire) begin
      if (dec.math_we) math_q <= lut_out;
      if (dec.wr_we)   wr_q   <= rdata;
    end
  end

  assign math_lo = math_q[OPND_W-1:0];
  assign math_hi = math_q[RES_W-1:OPND_W];
  assign cmp_lt  = flags[0];
  assign cmp_eq  = flags[1];
  assign cmp_gt  = flags[2];

  // R9: without an accepted instruction nothing architectural moves
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(math_q) && $stable(wr_q) && $stable(flags)));
  // R8: an unrecognised opcode leaves math, working register and flags alone
  assert_unknown_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !dec.known) |=> ($stable(math_q) && $stable(wr_q) && $stable(flags)));
endmodule

// File: tb/tb_lut_math_exec.sv
module tb_lut_math_exec;
  logic        clk = 1'b0;
  logic        rst_n, run, ins_valid, ld_valid;
  logic        ins_ready, ld_ready, cmp_lt, cmp_eq, cmp_gt;
  logic [7:0]  ins_opc, ins_hi, ins_lo, ins_imm, math_lo, math_hi;
  logic [19:0] ld_addr;
  logic [15:0] ld_data;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  lut_math_exec dut (
    .clk(clk), .rst_n(rst_n), .run(run), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_opc(ins_opc), .ins_hi(ins_hi), .ins_lo(ins_lo), .ins_imm(ins_imm),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .math_lo(math_lo), .math_hi(math_hi), .cmp_lt(cmp_lt), .cmp_eq(cmp_eq), .cmp_gt(cmp_gt)
  );

  function automatic logic [15:0] tval(int fs, int a, int b);
    logic [7:0] ab;
    ab = {a[3:0], b[3:0]};
    case (fs)
      0: return 16'(a + b);
      1: return 16'(a - b);
      2: return 16'(a * b);
      default: return {~ab, ab};
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [7:0] opc, logic [7:0] h, logic [7:0] l, logic [7:0] imm);
    @(negedge clk);
    ins_opc = opc; ins_hi = h; ins_lo = l; ins_imm = imm; ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 math", {math_hi, math_lo}, 16'h0000);
    check("R1 flags", {cmp_gt, cmp_eq, cmp_lt}, 3'b000);
    check("R1 ready", {ins_ready, ld_ready}, 2'b01);
  endtask

  task automatic t_load();
    for (int fs = 0; fs < 4; fs++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          ld_valid = 1'b1;
          ld_addr  = {4'(fs), 8'(a), 8'(b)};
          ld_data  = tval(fs, a, b);
        end
    @(negedge clk);
    ld_valid = 1'b0;
    run = 1'b1;
    #1;
    check("R1 ready in run", {ins_ready, ld_ready}, 2'b10);
  endtask

  task automatic t_regimm();
    issue(8'h10, 8'd0, 8'd5, 8'h09);
    check("R4 add zero reg", {math_hi, math_lo}, 16'h0009);
    issue(8'h13, 8'd0, 8'd1, 8'h07);
    check("R4 cat", {math_hi, math_lo}, 16'hF807);
  endtask

  task automatic t_store();
    issue(8'h50, 8'd0, 8'd1, 8'h00);
    check("R7 store lo keeps math", {math_hi, math_lo}, 16'hF807);
    issue(8'h13, 8'd0, 8'd1, 8'h0C);
    check("R7 reg1 is 7 via lookup", {math_hi, math_lo}, 16'h837C);
    issue(8'h60, 8'd0, 8'd2, 8'h00);
    issue(8'h40, 8'd0, 8'd2, 8'h83);
    check("R7 store hi", {cmp_gt, cmp_eq, cmp_lt}, 3'b010);
  endtask

  task automatic t_cmp();
    issue(8'h40, 8'd0, 8'd2, 8'h90);
    check("R6 less", {cmp_gt, cmp_eq, cmp_lt}, 3'b001);
    issue(8'h40, 8'd0, 8'd2, 8'h10);
    check("R6 greater", {cmp_gt, cmp_eq, cmp_lt}, 3'b100);
    check("R6 math untouched", {math_hi, math_lo}, 16'h837C);
  endtask

  task automatic t_addr();
    issue(8'h50, 8'd126, 8'd64, 8'h00);
    issue(8'h40, 8'd2, 8'd64, 8'h7C);
    check("R2 alias 126,64 -> 2,64", {cmp_gt, cmp_eq, cmp_lt}, 3'b010);
    issue(8'h40, 8'd126, 8'd65, 8'h01);
    check("R2 neighbour untouched", {cmp_gt, cmp_eq, cmp_lt}, 3'b001);
    issue(8'h40, 8'd126, 8'd64, 8'h7C);
    check("R2 direct", {cmp_gt, cmp_eq, cmp_lt}, 3'b010);
  endtask

  task automatic t_fold();
    issue(8'h16, 8'd0, 8'd1, 8'h13);
    check("R3 folded sel and operand", {math_hi, math_lo}, 16'h0015);
    issue(8'h11, 8'd0, 8'd1, 8'h03);
    check("R3 sub order", {math_hi, math_lo}, 16'h0004);
  endtask

  task automatic t_pair();
    issue(8'h20, 8'd0, 8'd1, 8'h00);
    check("R5 lwr keeps math", {math_hi, math_lo}, 16'h0004);
    issue(8'h31, 8'd0, 8'd2, 8'h00);
    check("R5 wr minus reg", {math_hi, math_lo}, 16'h0004);
    issue(8'h33, 8'd0, 8'd2, 8'h00);
    check("R5 operand order", {math_hi, math_lo}, 16'h8C73);
  endtask

  task automatic t_unknown();
    issue(8'h40, 8'd0, 8'd2, 8'h83);
    issue(8'h21, 8'd0, 8'd2, 8'h00);
    issue(8'h7F, 8'd0, 8'd1, 8'h05);
    issue(8'h00, 8'd0, 8'd1, 8'h05);
    issue(8'h41, 8'd0, 8'd2, 8'h00);
    issue(8'h51, 8'd0, 8'd5, 8'h00);
    check("R8 math held", {math_hi, math_lo}, 16'h8C73);
    check("R8 flags held", {cmp_gt, cmp_eq, cmp_lt}, 3'b010);
    issue(8'h30, 8'd0, 8'd2, 8'h00);
    check("R8 wr held", {math_hi, math_lo}, 16'h000A);
    issue(8'h40, 8'd0, 8'd5, 8'h01);
    check("R8 reg5 held", {cmp_gt, cmp_eq, cmp_lt}, 3'b001);
  endtask

  task automatic t_idle();
    run = 1'b0;
    issue(8'h13, 8'd0, 8'd1, 8'h0F);
    check("R9 run low math", {math_hi, math_lo}, 16'h000A);
    check("R9 run low ready", ins_ready, 1'b0);
    run = 1'b1;
    @(negedge clk);
    ins_opc = 8'h40; ins_hi = 8'd0; ins_lo = 8'd2; ins_imm = 8'h83; ins_valid = 1'b0;
    @(negedge clk);
    check("R9 valid low flags", {cmp_gt, cmp_eq, cmp_lt}, 3'b001);
  endtask

  task automatic t_ldblock();
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 20'h00000; ld_data = 16'hBEEF;
    #1;
    check("R10 refused", ld_ready, 1'b0);
    @(negedge clk);
    ld_valid = 1'b0;
    issue(8'h10, 8'd0, 8'd5, 8'h00);
    check("R10 table unchanged", {math_hi, math_lo}, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; ins_valid = 1'b0; ld_valid = 1'b0;
    ins_opc = '0; ins_hi = '0; ins_lo = '0; ins_imm = '0; ld_addr = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_regimm();
    t_store();
    t_cmp();
    t_addr();
    t_fold();
    t_pair();
    t_unknown();
    t_idle();
    t_ldblock();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule